// File: doc/BRIEF.md
# DMA Transfer Mode Controller

This block runs the per-transfer bookkeeping and the end-of-service logic of one DMA channel. A separate strobe sequencer performs the bus cycles and sends a one-cycle completion pulse after each transfer. On each pulse the controller steps the current address up or down. It decrements the current word count. It then decides whether the service keeps the bus or gives it back. When the count rolls over or an external end-of-process input arrives, it emits a one-cycle end-of-process pulse. It then either reloads the channel from its base values or masks the channel.

Four service modes are selected on the `mode` input: `2'b00` demand, `2'b01` single, `2'b10` block and `2'b11` cascade.
- Single mode gives the bus back after every transfer.
- Block mode runs until the count rolls over or an external end-of-process arrives.
- Demand mode also stops when the request falls. In that case the current registers are kept so the service can resume later.
- Cascade mode hands the request and acknowledge lines straight through to and from a downstream controller.

The state machine has five states:
- `ST_IDLE`: no service in progress. It goes to `ST_CASCADE` when the mode is cascade. It goes to `ST_HOLD_REQ` on an unmasked request while the hold acknowledge is low.
- `ST_HOLD_REQ`: the hold request is raised. It goes to `ST_WORK` when `hlda` is high.
- `ST_WORK`: the channel is acknowledged and transfers run. On a completion pulse it does one of three things:
  - goes to `ST_EOP` on terminal count or external end-of-process;
  - returns to `ST_IDLE` on a release;
  - stays in `ST_WORK` to continue.
- `ST_EOP`: the end-of-process cycle, which does the reload or the masking. It always goes back to `ST_IDLE`.
- `ST_CASCADE`: the pass-through state. It returns to `ST_IDLE` when the mode is no longer cascade.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, `hrq`, `dack`, `eop_out`, `svc_continue`, `svc_release`, `tc_flag` and `masked` are 0, and `cur_addr` and `cur_count` are 0.
- R2: A `prog_load` pulse copies `prog_addr`/`prog_count` into both the base and the current registers, and clears `masked` and `tc_flag`. The new values are visible in the next cycle.
- R3: Each accepted completion pulse (`xfer_done` while `dack` is high) decrements `cur_count` by 1. In the same edge it moves `cur_addr` by 1: down when `addr_dec`=1, up when `addr_dec`=0. Both wrap modulo 2^width.
- R4: A completion pulse taken while `cur_count` is 0 is a terminal count. `cur_count` becomes all ones, `tc_flag` is set (sticky until the next load), and `eop_out` is high for exactly the one following cycle.
- R5: At the end of the `eop_out` cycle there are two cases. With `autoinit_en`=1 the current registers reload from the base registers and `masked` stays 0. Otherwise `masked` becomes 1 and the current registers keep their values.
- R6: In single mode every completion pulse gives `svc_release`=1 and `svc_continue`=0, and `hrq` is low in the next cycle. A new service starts only after `hlda` has been seen low.
- R7: In block mode a completion pulse that is neither terminal count nor external end-of-process gives `svc_continue`=1, and `dack` stays high whatever `dreq` does.
- R8: In demand mode a completion pulse with `dreq` low gives `svc_release`=1 with no `eop_out`. The current registers are kept, `masked` is unchanged and no reload happens. A later request resumes from the kept values.
- R9: `eop_in` high in any cycle of `ST_WORK` ends the service at the next completion pulse, or at once if `eop_in` comes with that pulse. `eop_out` then pulses without setting `tc_flag`.
- R10: In cascade mode, from the cycle after the mode is selected, `hrq` follows `dreq` and `dack` follows `hlda` in the same cycle. `cur_addr` and `cur_count` do not change.
- R11: While `masked` is 1, `dreq` raises no `hrq` in demand, single or block mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 demand, 01 single, 10 block, 11 cascade |
| addr_dec | input | 1 | 1: address steps down, 0: steps up |
| autoinit_en | input | 1 | Reload from base at end of service |
| prog_load | input | 1 | Load base and current registers |
| prog_addr | input | AW | Start address to load |
| prog_count | input | CW | Word count to load (transfers = count+1) |
| dreq | input | 1 | Channel request (downstream hold request in cascade) |
| hlda | input | 1 | Hold acknowledge from the bus owner |
| xfer_done | input | 1 | One-cycle completion pulse from the sequencer |
| eop_in | input | 1 | External end-of-process, active high |
| hrq | output | 1 | Hold request |
| dack | output | 1 | Channel acknowledge |
| svc_continue | output | 1 | Service keeps the bus after this transfer |
| svc_release | output | 1 | Service gives up the bus after this transfer |
| eop_out | output | 1 | One-cycle end-of-process pulse |
| tc_flag | output | 1 | Sticky terminal-count status |
| masked | output | 1 | Channel mask state |
| cur_addr | output | AW | Current address |
| cur_count | output | CW | Current word count |

## Verification
On every cycle, the assertions check five things:
- the count step and the reload values;
- that the end-of-process pulse lasts a single cycle and follows a terminal count;
- that a release drops the hold request and single mode never continues;
- that a masked channel raises no request;
- that block mode keeps the acknowledge through a non-final transfer.

Three behaviours show up only in the bench's scenarios, which track their own model of address and count:
- the exact address sequence in both directions, including wrap;
- demand-mode suspension and resumption with kept registers;
- a late external end-of-process, the need for a fresh acknowledge after a single-mode release, and the cascade pass-through.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        MODE_DEMAND  = 2'b00,
        MODE_SINGLE  = 2'b01,
        MODE_BLOCK   = 2'b10,
        MODE_CASCADE = 2'b11
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HOLD_REQ = 3'd1,
        ST_WORK     = 3'd2,
        ST_EOP      = 3'd3,
        ST_CASCADE  = 3'd4
    } svc_state_e;

endpackage

// File: rtl/dma_cur_regs.sv
module dma_cur_regs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [CW-1:0] base_cnt_i,
    input  logic          step_i,
    input  logic          dec_i,
    input  logic          reload_i,
    output logic [AW-1:0] cur_addr_o,
    output logic [CW-1:0] cur_cnt_o,
    output logic          cnt_zero_o
);
    localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CNT_ONE  = {{(CW-1){1'b0}}, 1'b1};

    logic [AW-1:0] base_addr_q;
    logic [CW-1:0] base_cnt_q;
    logic [AW-1:0] addr_stepped;

    // Direction picks the adder or the subtractor for the next address.
    assign addr_stepped = dec_i ? (cur_addr_o - ADDR_ONE) : (cur_addr_o + ADDR_ONE);
    assign cnt_zero_o   = (cur_cnt_o == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
            cur_addr_o  <= '0;
            cur_cnt_o   <= '0;
        end else if (load_i) begin
            base_addr_q <= base_addr_i;
            base_cnt_q  <= base_cnt_i;
            cur_addr_o  <= base_addr_i;
            cur_cnt_o   <= base_cnt_i;
        end else if (reload_i) begin
            cur_addr_o  <= base_addr_q;
            cur_cnt_o   <= base_cnt_q;
        end else if (step_i) begin
            cur_addr_o  <= addr_stepped;
            cur_cnt_o   <= cur_cnt_o - CNT_ONE;
        end
    end

    // R3: one count per accepted transfer, rolling over from zero
    assert_step_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !reload_i) |=> (cur_cnt_o == $past(cur_cnt_o) - CNT_ONE));

    // R5: reload restores the programmed base values
    assert_reload_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !load_i) |=> (cur_addr_o == $past(base_addr_q) && cur_cnt_o == $past(base_cnt_q)));

endmodule

// File: rtl/dma_term_fsm.sv
module dma_term_fsm
    import dma_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       autoinit_i,
    input  logic       load_i,
    input  logic       dreq_i,
    input  logic       hlda_i,
    input  logic       done_i,
    input  logic       eop_i,
    input  logic       cnt_zero_i,
    output logic       hrq_o,
    output logic       dack_o,
    output logic       step_o,
    output logic       reload_o,
    output logic       eop_o,
    output logic       tc_o,
    output logic       masked_o,
    output logic       cont_o,
    output logic       rel_o
);
    svc_state_e st, st_nx;
    xfer_mode_e md;
    logic       eop_pend;
    logic       fin_w;

    assign md     = xfer_mode_e'(mode_i);
    assign step_o = (st == ST_WORK) && done_i;
    // Service ends on rollover or on an external end-of-process, now or earlier.
    assign fin_w  = cnt_zero_i || eop_pend || eop_i;
    assign cont_o = step_o && !fin_w &&
                    ((md == MODE_BLOCK) || ((md == MODE_DEMAND) && dreq_i));
    assign rel_o  = step_o && !cont_o;
    assign reload_o = (st == ST_EOP) && autoinit_i;

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (md == MODE_CASCADE)
                    st_nx = ST_CASCADE;
                else if (dreq_i && !masked_o && !hlda_i)
                    st_nx = ST_HOLD_REQ;
            end
            ST_HOLD_REQ: begin
                if (hlda_i)
                    st_nx = ST_WORK;
            end
            ST_WORK: begin
                if (step_o) begin
                    if (fin_w)
                        st_nx = ST_EOP;
                    else if (!cont_o)
                        st_nx = ST_IDLE;
                end
            end
            ST_EOP: st_nx = ST_IDLE;
            ST_CASCADE: begin
                if (md != MODE_CASCADE)
                    st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // Output decode
    always_comb begin
        hrq_o  = 1'b0;
        dack_o = 1'b0;
        eop_o  = 1'b0;
        unique case (st)
            ST_IDLE:     ;
            ST_HOLD_REQ: hrq_o = 1'b1;
            ST_WORK: begin
                hrq_o  = 1'b1;
                dack_o = 1'b1;
            end
            ST_EOP:      eop_o = 1'b1;
            ST_CASCADE: begin
                hrq_o  = dreq_i;
                dack_o = hlda_i;
            end
            default: ;
        endcase
    end

    // Status, mask and pending external end-of-process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_pend <= 1'b0;
            tc_o     <= 1'b0;
            masked_o <= 1'b0;
        end else begin
            eop_pend <= (st == ST_WORK) && !step_o && (eop_pend || eop_i);
            if (load_i)
                tc_o <= 1'b0;
            else if (step_o && cnt_zero_i)
                tc_o <= 1'b1;
            if (load_i)
                masked_o <= 1'b0;
            else if ((st == ST_EOP) && !autoinit_i)
                masked_o <= 1'b1;
        end
    end

    // R4: the end-of-process pulse lasts one cycle
    assert_eop_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |=> !eop_o);

    // R4: a terminal count raises status and end-of-process
    assert_tc_reports_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && cnt_zero_i && !load_i) |=> (tc_o && eop_o));

    // R6: a release drops the hold request
    assert_release_drops_hrq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o |=> !hrq_o);

    // R6: single mode never keeps the bus
    assert_single_no_continue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MODE_SINGLE) |-> !cont_o);

    // R7: block mode keeps the acknowledge through a non-final transfer
    assert_block_keeps_dack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && md == MODE_BLOCK && !cnt_zero_i && !eop_i && !eop_pend) |=> dack_o);

    // R11: a masked idle channel raises no request
    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_o && st == ST_IDLE && md != MODE_CASCADE) |=> !hrq_o);

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          addr_dec,
    input  logic          autoinit_en,
    input  logic          prog_load,
    input  logic [AW-1:0] prog_addr,
    input  logic [CW-1:0] prog_count,
    input  logic          dreq,
    input  logic          hlda,
    input  logic          xfer_done,
    input  logic          eop_in,
    output logic          hrq,
    output logic          dack,
    output logic          svc_continue,
    output logic          svc_release,
    output logic          eop_out,
    output logic          tc_flag,
    output logic          masked,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_count
);
    logic step_w;
    logic reload_w;
    logic cnt_zero_w;

    dma_cur_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (prog_load),
        .base_addr_i (prog_addr),
        .base_cnt_i  (prog_count),
        .step_i      (step_w),
        .dec_i       (addr_dec),
        .reload_i    (reload_w),
        .cur_addr_o  (cur_addr),
        .cur_cnt_o   (cur_count),
        .cnt_zero_o  (cnt_zero_w)
    );

    dma_term_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .autoinit_i (autoinit_en),
        .load_i     (prog_load),
        .dreq_i     (dreq),
        .hlda_i     (hlda),
        .done_i     (xfer_done),
        .eop_i      (eop_in),
        .cnt_zero_i (cnt_zero_w),
        .hrq_o      (hrq),
        .dack_o     (dack),
        .step_o     (step_w),
        .reload_o   (reload_w),
        .eop_o      (eop_out),
        .tc_o       (tc_flag),
        .masked_o   (masked),
        .cont_o     (svc_continue),
        .rel_o      (svc_release)
    );

endmodule

// File: tb/test_dma_xfer_ctrl.sv
module test_dma_xfer_ctrl;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam logic [1:0] M_DEM = 2'b00, M_SGL = 2'b01, M_BLK = 2'b10, M_CAS = 2'b11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = M_BLK;
    logic addr_dec = 1'b0, autoinit_en = 1'b0, prog_load = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [CW-1:0] prog_count = '0;
    logic dreq = 1'b0, hlda = 1'b0, xfer_done = 1'b0, eop_in = 1'b0;
    logic hrq, dack, svc_continue, svc_release, eop_out, tc_flag, masked;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;

    int tests = 0, fails = 0, cyc = 0;
    logic [AW-1:0] m_addr, b_addr;
    logic [CW-1:0] m_cnt, b_cnt;
    bit m_tc, m_dec, m_ai;
    logic [1:0] m_mode;

    dma_xfer_ctrl #(.AW(AW), .CW(CW)) i_dma_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr_dec(addr_dec),
        .autoinit_en(autoinit_en), .prog_load(prog_load), .prog_addr(prog_addr),
        .prog_count(prog_count), .dreq(dreq), .hlda(hlda), .xfer_done(xfer_done),
        .eop_in(eop_in), .hrq(hrq), .dack(dack), .svc_continue(svc_continue),
        .svc_release(svc_release), .eop_out(eop_out), .tc_flag(tc_flag),
        .masked(masked), .cur_addr(cur_addr), .cur_count(cur_count));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input bit dec);
        return dec ? a - 1'b1 : a + 1'b1;
    endfunction

    function automatic bit keeps_bus(input logic [1:0] md, input bit fin, input bit req);
        return !fin && (md == M_BLK || (md == M_DEM && req));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic program_ch(input logic [1:0] md, input logic [AW-1:0] a, input logic [CW-1:0] c,
                              input bit dec, input bit ai);
        @(negedge clk);
        mode = md; addr_dec = dec; autoinit_en = ai;
        prog_addr = a; prog_count = c; prog_load = 1'b1;
        @(negedge clk);
        prog_load = 1'b0;
        m_mode = md; m_addr = a; m_cnt = c; b_addr = a; b_cnt = c;
        m_dec = dec; m_ai = ai; m_tc = 0;
        chk(cur_addr == a && cur_count == c, "R2 load", {cur_addr, cur_count}, {a, c});
        chk(!masked && !tc_flag, "R2 clear", {masked, tc_flag}, 0);
    endtask

    task automatic grant();
        for (int k = 0; k < 10 && !hrq; k++) @(negedge clk);
        chk(hrq, "R6 hrq raised", hrq, 1);
        hlda = 1'b1;
        @(negedge clk);
        chk(dack, "R7 dack after hlda", dack, 1);
    endtask

    // Called at a negedge with dack high.
    task automatic one_xfer(input bit ext, input bit drop, output bit ended, output bit rel);
        bit tc, cont;
        tc = (m_cnt == '0);
        ended = tc || ext;
        cont = keeps_bus(m_mode, ended, !drop);
        rel = !cont;
        xfer_done = 1'b1; eop_in = ext;
        if (drop) dreq = 1'b0;
        #1;
        chk(svc_continue == cont, m_mode == M_SGL ? "R6 continue" : "R7 continue", svc_continue, cont);
        chk(svc_release == rel, "R8 release", svc_release, rel);
        @(negedge clk);
        xfer_done = 1'b0; eop_in = 1'b0;
        m_cnt = m_cnt - 1'b1;
        m_addr = next_addr(m_addr, m_dec);
        if (tc) m_tc = 1;
        chk(cur_count == m_cnt, "R3 count", cur_count, m_cnt);
        chk(cur_addr == m_addr, "R3 addr", cur_addr, m_addr);
        if (ended) begin
            chk(eop_out == 1'b1, tc ? "R4 eop" : "R9 eop", eop_out, 1);
            chk(tc_flag == m_tc, tc ? "R4 tc flag" : "R9 tc flag", tc_flag, m_tc);
            chk(!hrq, "R6 hrq low at eop", hrq, 0);
            hlda = 1'b0; dreq = 1'b0;
            @(negedge clk);
            chk(!eop_out, "R4 eop one cycle", eop_out, 0);
            if (m_ai) begin
                m_addr = b_addr; m_cnt = b_cnt;
            end
            chk(masked == !m_ai, "R5 mask", masked, !m_ai);
            chk(cur_addr == m_addr && cur_count == m_cnt, "R5 regs", {cur_addr, cur_count}, {m_addr, m_cnt});
        end else if (rel) begin
            chk(!hrq && !eop_out, "R6 hrq released", {hrq, eop_out}, 0);
            hlda = 1'b0;
        end else begin
            chk(dack, "R7 dack kept", dack, 1);
        end
    endtask

    task automatic run_service(input int eop_at);
        bit ended, rel;
        int i;
        i = 0; ended = 0;
        dreq = 1'b1;
        while (!ended && i < 40) begin
            grant();
            rel = 0;
            while (!rel) begin
                one_xfer(i == eop_at, 0, ended, rel);
                i++;
            end
            if (!ended) dreq = 1'b1;
        end
    endtask

    initial begin
        bit ended, rel;
        repeat (3) @(negedge clk);
        chk(!hrq && !dack && !eop_out && !svc_continue && !svc_release, "R1 outputs", {hrq, dack, eop_out}, 0);
        chk(!tc_flag && !masked && cur_addr == 0 && cur_count == 0, "R1 state", {tc_flag, masked, cur_count}, 0);
        rst_n = 1'b1;

        // Block, count 2 upward, no autoinit: 3 transfers then mask.
        program_ch(M_BLK, 16'h1000, 16'd2, 0, 0);
        run_service(-1);
        // R11: masked channel ignores requests
        dreq = 1'b1;
        repeat (4) @(negedge clk);
        chk(!hrq, "R11 masked no hrq", hrq, 0);
        dreq = 1'b0;

        // Block, downward wrap from address 0, autoinit.
        program_ch(M_BLK, 16'h0000, 16'd1, 1, 1);
        run_service(-1);
        chk(!masked, "R5 autoinit keeps unmasked", masked, 0);

        // R9: external end-of-process pulsed early, takes effect at next transfer
        program_ch(M_BLK, 16'h2000, 16'd10, 0, 0);
        dreq = 1'b1;
        grant();
        one_xfer(0, 0, ended, rel);
        eop_in = 1'b1;
        @(negedge clk);
        eop_in = 1'b0;
        chk(dack && !eop_out, "R9 no early end", {dack, eop_out}, 2);
        one_xfer(1, 0, ended, rel);
        chk(ended && !tc_flag, "R9 ended without tc", {ended, tc_flag}, 2);

        // R6: single mode needs a fresh hlda
        program_ch(M_SGL, 16'h3000, 16'd5, 0, 0);
        dreq = 1'b1;
        grant();
        one_xfer(0, 0, ended, rel);
        hlda = 1'b1;
        repeat (3) @(negedge clk);
        chk(!hrq && !dack, "R6 waits for hlda low", {hrq, dack}, 0);
        hlda = 1'b0;
        grant();
        one_xfer(0, 0, ended, rel);
        dreq = 1'b0;

        // R8: demand suspend and resume
        program_ch(M_DEM, 16'h4000, 16'd3, 0, 1);
        dreq = 1'b1;
        grant();
        one_xfer(0, 0, ended, rel);
        one_xfer(0, 1, ended, rel);
        chk(rel && !ended, "R8 release on drop", {rel, ended}, 2);
        repeat (3) @(negedge clk);
        chk(!eop_out && !masked && cur_count == m_cnt && cur_addr == m_addr, "R8 kept",
            cur_count, m_cnt);
        run_service(-1);

        // R10: cascade pass-through
        program_ch(M_CAS, 16'h5000, 16'd7, 0, 0);
        @(negedge clk);
        dreq = 1'b1; hlda = 1'b0; #1;
        chk(hrq && !dack, "R10 hrq follows dreq", {hrq, dack}, 2);
        hlda = 1'b1; #1;
        chk(dack, "R10 dack follows hlda", dack, 1);
        dreq = 1'b0; #1;
        chk(!hrq, "R10 hrq drops", hrq, 0);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0; hlda = 1'b0; mode = M_BLK;
        chk(cur_count == 16'd7 && cur_addr == 16'h5000, "R10 regs untouched", cur_count, 7);
        @(negedge clk);

        // Constrained random services
        void'($urandom(32'h5eed_0042));
        for (int n = 0; n < 40; n++) begin
            logic [1:0] md;
            int cnt, ea;
            md = 2'($urandom_range(0, 2));
            cnt = $urandom_range(0, 4);
            ea = ($urandom_range(0, 2) == 0) ? $urandom_range(0, cnt) : -1;
            program_ch(md, 16'($urandom), 16'(cnt), 1'($urandom), 1'($urandom));
            run_service(ea);
            repeat (2) @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule